// File: doc/BRIEF.md
# Set/Clear GPIO Port with Armed Input Path

This block is a 32-pin general-purpose I/O port on a small register bus. Software changes output levels through two write-only ports. One port drives the selected pins high and the other drives them low. Bits written as 0 leave the matching pins untouched, so no read-modify-write is needed. A write to either port also makes every selected pin an output. A third write-only port returns the selected pins to input (high-impedance) mode. The output latch of those pins keeps its value.

The live pin levels are read through a pin-state register. The external levels pass through a two-flop synchronizer. The sampled value stays hidden, and the register reads as zero, until software has written the input-arm register once after reset. The data of that write is ignored. The block drives per-pin output-value and output-enable signals toward the pad ring, and it receives the pad levels back on a separate input vector.

Top module: `gpio_setclr_port`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `pin_out`, `pin_oe` and `rdata` are all zero, and the input path is disarmed.
- R2: A write to address 0 (set port) makes `pin_out[i]` 1 for every bit i that is 1 in `wdata`, starting in the cycle after the write edge. Bits written as 0 keep their value.
- R3: A write to address 1 (clear port) makes `pin_out[i]` 0 for every bit i that is 1 in `wdata`, starting in the cycle after the write edge. Bits written as 0 keep their value.
- R4: A write to address 0 or address 1 sets `pin_oe[i]` to 1 for every bit i that is 1 in `wdata`. The other enables are unchanged.
- R5: A write to address 2 (tristate-clear port) sets `pin_oe[i]` to 0 for every bit i that is 1 in `wdata`. All other enables and the whole of `pin_out` are unchanged.
- R6: A read of address 3 (pin-state register) returns zero until the input path has been armed, whatever the pin levels are.
- R7: Any write to address 4 arms the input path, whatever the value of `wdata`, including zero. The path stays armed until reset.
- R8: Once armed, a read of address 3 returns the pin levels through two synchronizer stages. `rdata` is registered and is valid in the cycle after the edge that samples `rd_en`. A read sampled at the first or second edge after `pin_in` changes still returns the old levels. A read sampled at the third edge returns the new levels.
- R9: Reads of any address other than 3 return zero. Writes to addresses 3, 5, 6 and 7 change neither `pin_out`, `pin_oe` nor the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register select |
| wdata | input | 32 | Write data, one bit per pin |
| rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pad levels |
| pin_out | output | 32 | Output latch per pin |
| pin_oe | output | 32 | Output enable per pin (1 = drive) |

## Verification
The assertions check the effects of every set, clear and tristate-clear write on the output and enable vectors on every cycle. They also check that writes to non-functional addresses leave both vectors unchanged, that reads stay zero before arming, and that the reset values hold. Three behaviours can only be shown by the bench's scenarios: the exact synchronizer latency, with its sequence of old, old and new values on back-to-back reads; that a write of zero to the arm register still arms the path; and that a second reset disarms the path again.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;
  localparam int ADDR_W = 3;

  // Register select; the offsets are what software decodes.
  typedef enum logic [ADDR_W-1:0] {
    REG_SET  = 3'd0,
    REG_CLR  = 3'd1,
    REG_TRI  = 3'd2,
    REG_PINS = 3'd3,
    REG_ARM  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_setclr_pkg::*;
(
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              do_set,
  output logic              do_clr,
  output logic              do_tri,
  output logic              do_arm,
  output logic              do_rd_pins
);
  always_comb begin
    do_set     = wr_en && (addr == REG_SET);
    do_clr     = wr_en && (addr == REG_CLR);
    do_tri     = wr_en && (addr == REG_TRI);
    do_arm     = wr_en && (addr == REG_ARM);
    do_rd_pins = rd_en && (addr == REG_PINS);
  end
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         do_set,
  input  logic         do_clr,
  input  logic         do_tri,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] pin_out,
  output logic [N-1:0] pin_oe
);
  // One latch pair per pin; a set or clear access claims the pin as output.
  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_out[i] <= 1'b0;
        pin_oe[i]  <= 1'b0;
      end else if (wdata[i]) begin
        if (do_set) begin
          pin_out[i] <= 1'b1;
          pin_oe[i]  <= 1'b1;
        end else if (do_clr) begin
          pin_out[i] <= 1'b0;
          pin_oe[i]  <= 1'b1;
        end else if (do_tri) begin
          pin_oe[i]  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         do_arm,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] pin_state
);
  logic [N-1:0] stage_q [STAGES];
  logic         armed_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= pin_in;
      else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  // The data of the arming write is deliberately not looked at.
  always_ff @(posedge clk) begin
    if (rst)         armed_q <= 1'b0;
    else if (do_arm) armed_q <= 1'b1;
  end

  assign pin_state = armed_q ? stage_q[STAGES-1] : '0;
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_setclr_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      rdata,
  input  logic [N-1:0]      pin_in,
  output logic [N-1:0]      pin_out,
  output logic [N-1:0]      pin_oe
);
  logic do_set, do_clr, do_tri, do_arm, do_rd_pins;
  logic [N-1:0] pin_state;

  gpio_reg_decode u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .do_set(do_set), .do_clr(do_clr), .do_tri(do_tri),
    .do_arm(do_arm), .do_rd_pins(do_rd_pins)
  );

  gpio_pin_bank #(.N(N)) u_bank (
    .clk(clk), .rst(rst),
    .do_set(do_set), .do_clr(do_clr), .do_tri(do_tri),
    .wdata(wdata), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  gpio_in_sync #(.N(N), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .do_arm(do_arm),
    .pin_in(pin_in), .pin_state(pin_state)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= do_rd_pins ? pin_state : '0;
  end
endmodule

// File: rtl/gpio_setclr_chk.sv
module gpio_setclr_chk
  import gpio_setclr_pkg::*;
#(
  parameter int N = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [N-1:0]      wdata,
  input logic [N-1:0]      rdata,
  input logic [N-1:0]      pin_out,
  input logic [N-1:0]      pin_oe
);
  logic seen_arm_q;
  always_ff @(posedge clk) begin
    if (rst) seen_arm_q <= 1'b0;
    else if (wr_en && addr == REG_ARM) seen_arm_q <= 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pin_out == '0 && pin_oe == '0 && rdata == '0));

  // R2
  set_drives_high_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_SET) |=> ((pin_out & $past(wdata)) == $past(wdata)));

  // R3
  clr_drives_low_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_CLR) |=> ((pin_out & $past(wdata)) == '0));

  // R4
  write_claims_output_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == REG_SET || addr == REG_CLR))
      |=> ((pin_oe & $past(wdata)) == $past(wdata)));

  // R5
  tri_releases_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_TRI)
      |=> (((pin_oe & $past(wdata)) == '0) && $stable(pin_out)));

  // R6
  unarmed_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!seen_arm_q && rd_en) |=> (rdata == '0));

  // R9
  dead_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr >= REG_PINS && addr != REG_ARM)
      |=> ($stable(pin_out) && $stable(pin_oe)));

  // R9
  other_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && addr == REG_PINS) |=> (rdata == '0));
endmodule

bind gpio_setclr_port gpio_setclr_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/sim_gpio_setclr_port.sv
`timescale 1ns/1ps
module sim_gpio_setclr_port;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [N-1:0] wdata = '0, pin_in = '0;
  logic [N-1:0] rdata, pin_out, pin_oe;

  int checks = 0, failures = 0;
  logic [N-1:0] m_out = '0, m_oe = '0;
  logic [N-1:0] rd_val;

  always #4 clk = ~clk;

  gpio_setclr_port #(.N(N)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [N-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    if (d != '0) begin
      case (a)
        3'd0: begin m_out = m_out | d;  m_oe = m_oe | d; end
        3'd1: begin m_out = m_out & ~d; m_oe = m_oe | d; end
        3'd2: m_oe = m_oe & ~d;
        default: ;
      endcase
    end
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [N-1:0] v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic chk_pins(input string req);
    chk({req, " out"}, pin_out, m_out);
    chk({req, " oe"},  pin_oe,  m_oe);
  endtask

  task automatic do_reset();
    rst = 1'b1; pin_in = '1;
    repeat (3) @(negedge clk);
    rst = 1'b0; m_out = '0; m_oe = '0;
  endtask

  initial begin
    #(8ns * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset values
    chk("R1 out", pin_out, '0);
    chk("R1 oe", pin_oe, '0);
    chk("R1 rdata", rdata, '0);

    // R6 unarmed with all pins high
    repeat (3) @(negedge clk);
    bus_read(3'd3, rd_val); chk("R6 unarmed read", rd_val, '0);

    // R9 writes to non-functional addresses change nothing and do not arm
    for (int a = 3; a < 8; a++) begin
      if (a != 4) begin
        bus_write(a[2:0], '1); chk_pins("R9 dead write");
      end
    end
    bus_read(3'd3, rd_val); chk("R9 no arm via dead write", rd_val, '0);

    // R2 R4 walking set
    for (int i = 0; i < N; i++) begin
      bus_write(3'd0, N'(1) << i); chk_pins("R2 R4 walk set");
    end
    // R3 R4 walking clear on odd bits
    for (int i = 1; i < N; i += 2) begin
      bus_write(3'd1, N'(1) << i); chk_pins("R3 R4 walk clr");
    end
    // R5 tristate-clear keeps the output latch
    bus_write(3'd2, 32'h0F0F_0F0F); chk_pins("R5 tri");
    bus_write(3'd2, 32'h0000_0000); chk_pins("R5 tri zero");
    bus_write(3'd0, 32'h0000_0000); chk_pins("R2 set zero");

    // R2 R3 R5 mixed arithmetic patterns
    for (int k = 0; k < 96; k++) begin
      logic [N-1:0] d;
      d = N'(k) * 32'h9E37_79B9 ^ (N'(k) << 7);
      bus_write(3'(k % 3), d); chk_pins("R2 R3 R5 mixed");
    end

    // R9 reads of other addresses
    for (int a = 0; a < 8; a++) begin
      if (a != 3) begin
        bus_read(a[2:0], rd_val); chk("R9 other read", rd_val, '0);
      end
    end

    // R7 arm with zero data
    pin_in = 32'hA5A5_5A5A;
    bus_write(3'd4, '0);
    repeat (2) @(negedge clk);
    bus_read(3'd3, rd_val); chk("R7 armed by zero write", rd_val, 32'hA5A5_5A5A);

    // R8 pattern sweep
    for (int k = 0; k < 40; k++) begin
      pin_in = (N'(1) << (k % N)) ^ (N'(k) * 32'h0101_0101);
      repeat (2) @(negedge clk);
      bus_read(3'd3, rd_val);
      chk("R8 sweep", rd_val, (N'(1) << (k % N)) ^ (N'(k) * 32'h0101_0101));
    end

    // R8 latency: old, old, new
    pin_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    pin_in = 32'hCAFE_F00D;
    bus_read(3'd3, rd_val); chk("R8 lat edge1", rd_val, 32'h1234_5678);
    bus_read(3'd3, rd_val); chk("R8 lat edge2", rd_val, 32'h1234_5678);
    bus_read(3'd3, rd_val); chk("R8 lat edge3", rd_val, 32'hCAFE_F00D);

    // R7 second arm write keeps the path armed
    bus_write(3'd4, '1);
    bus_read(3'd3, rd_val); chk("R7 rearm", rd_val, 32'hCAFE_F00D);

    // R1 R6 reset disarms again
    do_reset();
    chk("R1 out again", pin_out, '0);
    chk("R1 oe again", pin_oe, '0);
    repeat (3) @(negedge clk);
    bus_read(3'd3, rd_val); chk("R6 disarmed after reset", rd_val, '0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule